// File: doc/BRIEF.md
# Differential Spread-Spectrum Chip Generator

This block turns a slow serial data stream into a fast serial chip stream for a direct-sequence spread-spectrum transmitter. Each incoming data bit is first passed through a differential encoder, which XORs it with the previously encoded bit. The encoded bit then selects one of two complementary 15-chip pseudo-noise words, which are shifted out one chip per chip strobe. A chip strobe is derived by dividing the system clock by 106, so at 32 MHz a chip lasts about 3.31 µs and one data bit spans 15 chips.

The block is the data source for a pulse shaper that follows it. That stage latches `chip_out` on each `chip_stb`. On the input side, a framer is asked for the next data bit with a one-cycle `bit_req` pulse, issued one chip period before the current word ends. The framer answers with a single-cycle `bit_vld`. If no bit arrives in time, the block spreads a data 0, so the chip stream never pauses. The encoder keeps running in that case.

Top module: `dsss_chip_spreader`

## Requirements
- R1: While the synchronous reset `rst` is high, `chip_out`, `chip_stb` and `bit_req` are 0 from the first clock edge on, and the differential encoder state is cleared to 0.
- R2: `chip_stb` is a one-cycle pulse that repeats every `CLK_DIV` (default 106) clock cycles. The first pulse is visible `CLK_DIV` cycles after the first clock edge with `rst` low.
- R3: `chip_out` changes only in a cycle where `chip_stb` is high, and holds its value between strobes.
- R4: The encoded bit of a word is the accepted data bit XOR the encoded bit of the previous word.
- R5: An encoded 0 emits the word 111101011001000 and an encoded 1 emits its complement 000010100110111. Chips go out leftmost first.
- R6: Words follow each other without gaps. The first chip of a word comes exactly one chip period after the last chip of the previous word.
- R7: `bit_req` is high for exactly one cycle, together with the strobe that carries the last (15th) chip of each word, and never at any other time.
- R8: A bit is accepted when `bit_vld` is high in the `bit_req` cycle, or in any later cycle up to and including the cycle `CLK_DIV-2` cycles after the `bit_req` cycle. Only the first such bit is taken, and it is spread in the next word. A `bit_vld` one cycle later than that is too late.
- R9: `bit_vld` while no request is outstanding has no effect on the chip stream. A request stops being outstanding once a bit has been accepted, or once the next word has started.
- R10: If no bit is accepted for a word, data 0 is used: the word repeats the previous encoded bit, and the encoder state carries on from it.
- R11: The first word after reset carries data 0 and encoded 0, so it is 111101011001000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Data bit offered by the framer, one-cycle pulse |
| bit_in | input | 1 | Data bit value, read when `bit_vld` is high |
| bit_req | output | 1 | Request for the next data bit, one-cycle pulse |
| chip_out | output | 1 | Current chip, held between strobes |
| chip_stb | output | 1 | Chip strobe, one cycle per chip period |

## Verification
The checker assumes that reset is held for at least one clock edge before the first strobe is judged. It also assumes that the framer drives `bit_vld` only as single-cycle pulses. It places no other condition on the framer: offers at any time must leave the strobe cadence, the request position and the word structure intact. The bench answers each request from a random plan. The plan either skips the request, or answers after a delay that stays inside the acceptance window, sometimes followed by a stray offer of the opposite value. Directed requests probe the first and last cycle of the window and the first cycle past it.

// File: rtl/dsss_spread_pkg.sv
package dsss_spread_pkg;

    localparam int unsigned DEF_CLK_DIV = 106;
    localparam int unsigned DEF_SEQ_LEN = 15;
    localparam logic [DEF_SEQ_LEN-1:0] DEF_SEQ0 = 15'b111101011001000;

    // one data bit waiting to be spread
    typedef struct packed {
        logic valid;
        logic data;
    } held_bit_t;

endpackage

// File: rtl/dsss_chip_timer.sv
module dsss_chip_timer #(
    parameter int unsigned CLK_DIV = dsss_spread_pkg::DEF_CLK_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == TOP);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dsss_bit_latch.sv
module dsss_bit_latch
    import dsss_spread_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_pulse,
    input  logic      seq_start,
    input  logic      bit_vld,
    input  logic      bit_in,
    output held_bit_t slot
);
    typedef struct packed {
        logic      pend;
        held_bit_t slot;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic      take;

    always_comb begin
        st_d = st_q;
        take = bit_vld && (req_pulse || st_q.pend) && !seq_start;
        if (seq_start) begin
            st_d.slot = '0;
            st_d.pend = 1'b0;
        end else if (take) begin
            st_d.slot = '{valid: 1'b1, data: bit_in};
            st_d.pend = 1'b0;
        end else if (req_pulse) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slot = st_q.slot;
endmodule

// File: rtl/dsss_chip_spreader.sv
module dsss_chip_spreader
    import dsss_spread_pkg::*;
#(
    parameter int unsigned           CLK_DIV = DEF_CLK_DIV,
    parameter int unsigned           SEQ_LEN = DEF_SEQ_LEN,
    parameter logic [SEQ_LEN-1:0]    SEQ0    = DEF_SEQ0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic bit_req,
    output logic chip_out,
    output logic chip_stb
);
    localparam int unsigned IW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(SEQ_LEN - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          enc;
        logic          chip;
        logic          stb;
        logic          req;
    } spread_st_t;

    spread_st_t s_d, s_q;
    logic       tick;
    logic       seq_start;
    held_bit_t  slot;
    logic       enc_now;
    logic [IW-1:0] pos;

    dsss_chip_timer #(.CLK_DIV(CLK_DIV)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign seq_start = tick && (s_q.idx == '0);

    dsss_bit_latch latch_i (
        .clk       (clk),
        .rst       (rst),
        .req_pulse (s_q.req),
        .seq_start (seq_start),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .slot      (slot)
    );

    always_comb begin
        s_d     = s_q;
        s_d.stb = tick;
        s_d.req = 1'b0;
        enc_now = (s_q.idx == '0) ? (s_q.enc ^ (slot.valid & slot.data)) : s_q.enc;
        pos     = LAST - s_q.idx;
        if (tick) begin
            s_d.enc  = enc_now;
            s_d.chip = SEQ0[pos] ^ enc_now;
            s_d.req  = (s_q.idx == LAST);
            s_d.idx  = (s_q.idx == LAST) ? '0 : s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign chip_out = s_q.chip;
    assign chip_stb = s_q.stb;
    assign bit_req  = s_q.req;
endmodule

// File: rtl/dsss_chip_spreader_chk.sv
module dsss_chip_spreader_chk #(
    parameter int unsigned        CLK_DIV = 106,
    parameter int unsigned        SEQ_LEN = 15,
    parameter logic [SEQ_LEN-1:0] SEQ0    = 15'b111101011001000
) (
    input logic clk,
    input logic rst,
    input logic bit_vld,
    input logic bit_in,
    input logic bit_req,
    input logic chip_out,
    input logic chip_stb
);
    localparam int unsigned GW = $clog2(CLK_DIV + 2);
    localparam int unsigned IW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(SEQ_LEN - 1);
    localparam logic [GW-1:0] GAP_FIRST = GW'(CLK_DIV);
    localparam logic [GW-1:0] GAP_NEXT  = GW'(CLK_DIV - 1);

    logic [GW-1:0] gap_q;
    logic          first_q;
    logic [IW-1:0] sc_q;
    logic          inv_q;
    logic [IW-1:0] pos;

    assign pos = LAST - sc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            first_q <= 1'b1;
            sc_q    <= '0;
            inv_q   <= 1'b0;
        end else if (chip_stb) begin
            gap_q   <= '0;
            first_q <= 1'b0;
            sc_q    <= (sc_q == LAST) ? '0 : sc_q + 1'b1;
            if (sc_q == '0) inv_q <= chip_out ^ SEQ0[SEQ_LEN-1];
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!chip_stb && !bit_req && !chip_out)); // R1
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        chip_stb |=> !chip_stb); // R2
    AST_STB_PERIOD: assert property (@(posedge clk) disable iff (rst)
        chip_stb |-> (gap_q == (first_q ? GAP_FIRST : GAP_NEXT))); // R2
    AST_CHIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !chip_stb |-> $stable(chip_out)); // R3
    AST_WORD_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (chip_stb && sc_q != '0) |-> (chip_out == (SEQ0[pos] ^ inv_q))); // R5
    AST_REQ_LAST: assert property (@(posedge clk) disable iff (rst)
        bit_req |-> (chip_stb && sc_q == LAST)); // R7
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_req |=> !bit_req); // R7
endmodule

bind dsss_chip_spreader dsss_chip_spreader_chk #(
    .CLK_DIV (CLK_DIV),
    .SEQ_LEN (SEQ_LEN),
    .SEQ0    (SEQ0)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .bit_req  (bit_req),
    .chip_out (chip_out),
    .chip_stb (chip_stb)
);

// File: tb/dsss_chip_spreader_tb.sv
module dsss_chip_spreader_tb_top;
    localparam int DIV = 106;
    localparam logic [14:0] S0 = 15'b111101011001000;

    logic clk = 1'b0;
    logic rst;
    logic bit_vld;
    logic bit_in;
    logic bit_req;
    logic chip_out;
    logic chip_stb;

    always #5 clk = ~clk;

    dsss_chip_spreader dut_i (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .bit_req  (bit_req),
        .chip_out (chip_out),
        .chip_stb (chip_stb)
    );

    int checks = 0;
    int errors = 0;
    int cyc, last_stb, total, chips, req_count;
    int idx_m;
    logic enc_m;
    logic [14:0] cur_seq;
    string cur_tag;
    logic q_dat[$];
    string q_tag[$];
    logic held, r3_bad, wd;
    logic armed, drv_dat, drv_push, stray_plan;
    int wait_cnt, stray_cnt;
    string drv_tag;

    function automatic logic [14:0] word_for(input logic enc);
        return enc ? ~S0 : S0;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic plan_request();
        int r;
        req_count++;
        stray_plan = 1'b0;
        drv_push   = 1'b1;
        armed      = 1'b1;
        case (req_count)
            1: begin wait_cnt = 0;   drv_dat = 1'b1; drv_tag = "R8"; end
            2: begin wait_cnt = 104; drv_dat = 1'b1; drv_tag = "R8"; end
            3: begin // one cycle too late: word must carry data 0
                wait_cnt = 105; drv_dat = 1'b1; drv_push = 1'b0;
                q_dat.push_back(1'b0); q_tag.push_back("R8");
            end
            4: begin armed = 1'b0; q_dat.push_back(1'b0); q_tag.push_back("R10"); end
            5: begin wait_cnt = 5; drv_dat = 1'b0; drv_tag = "R9"; stray_plan = 1'b1; end
            default: begin
                r = int'($urandom % 10);
                if (r < 2) begin
                    armed = 1'b0;
                    q_dat.push_back(1'b0); q_tag.push_back("R10");
                end else begin
                    wait_cnt   = int'($urandom % 40);
                    drv_dat    = 1'($urandom);
                    stray_plan = (r < 5);
                    drv_tag    = stray_plan ? "R9" : "R4";
                end
            end
        endcase
    endtask

    task automatic step();
        logic exp;
        @(negedge clk);
        total++;
        cyc++;
        bit_vld = 1'b0;
        if (chip_stb) begin
            check(cyc - last_stb == DIV, (idx_m == 0) ? "R6" : "R2", cyc - last_stb, DIV);
            last_stb = cyc;
            check(!r3_bad, "R3", int'(r3_bad), 0);
            if (idx_m == 0) begin
                if (q_dat.size() == 0) begin
                    check(1'b0, "R8", 0, 1);
                    cur_tag = "R10";
                    enc_m   = enc_m;
                end else begin
                    enc_m   = enc_m ^ q_dat.pop_front();
                    cur_tag = q_tag.pop_front();
                end
                cur_seq = word_for(enc_m);
            end
            exp = cur_seq[14 - idx_m];
            // chip value follows R4 encoding and R5 word shape
            check(chip_out == exp, cur_tag, int'(chip_out), int'(exp));
            check(bit_req == (idx_m == 14), "R7", int'(bit_req), int'(idx_m == 14));
            held   = chip_out;
            r3_bad = 1'b0;
            idx_m  = (idx_m == 14) ? 0 : idx_m + 1;
            chips++;
        end else begin
            if (chip_out !== held) r3_bad = 1'b1;
            if (bit_req) check(1'b0, "R7", 1, 0);
        end
        if (bit_req) plan_request();
        if (armed) begin
            if (wait_cnt == 0) begin
                bit_vld = 1'b1;
                bit_in  = drv_dat;
                armed   = 1'b0;
                if (drv_push) begin
                    q_dat.push_back(drv_dat);
                    q_tag.push_back(drv_tag);
                end
                if (stray_plan) stray_cnt = 3;
            end else begin
                wait_cnt--;
            end
        end else if (stray_cnt > 0) begin
            stray_cnt--;
            if (stray_cnt == 0) begin
                bit_vld = 1'b1;
                bit_in  = ~drv_dat;
            end
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        bit_vld   = 1'b0;
        bit_in    = 1'b0;
        armed     = 1'b0;
        stray_cnt = 0;
        repeat (3) begin
            @(negedge clk);
            total++;
            check(!chip_stb && !bit_req && !chip_out, "R1",
                  int'({chip_stb, bit_req, chip_out}), 0);
        end
        q_dat.delete();
        q_tag.delete();
        q_dat.push_back(1'b0);
        q_tag.push_back("R11");
        enc_m    = 1'b0;
        idx_m    = 0;
        held     = 1'b0;
        r3_bad   = 1'b0;
        cyc      = 0;
        last_stb = 0;
        rst      = 1'b0;
    endtask

    task automatic run_words(input int nwords);
        int target;
        target = chips + nwords * 15;
        while (chips < target && !wd) begin
            step();
            if (total > 150000) begin
                wd = 1'b1;
                check(1'b0, "R2 watchdog", chips, target);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        total = 0; chips = 0; req_count = 0; wd = 1'b0;
        do_reset();
        run_words(40);
        if (!wd) begin
            do_reset();
            run_words(20);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule